// File: doc/BRIEF.md
# Boot-time ECC scrub sequencer

This controller runs once per start request, before a processing core is released for use. It initializes the ECC-protected storage in that core. When it accepts a start, it first works out which ECC units are switched on. It uses three sources for this: a global ECC fuse, a fuse that locks out software overrides, and two override words that carry override/value bit pairs. The six resolved enables are captured and shown on an output.

The controller then steps through the five scrubbable units in a fixed order. For each enabled unit it issues one register write that launches every scrub task of that unit together. It then reads the unit's status register until the task bits have cleared. The reads are paced by a fixed interval and capped by a poll limit. A unit that never clears is marked failed, and the sequence moves on to the next unit. A one-cycle done pulse closes the run. All accesses go through a single-outstanding request/acknowledge register master port.

Top module: `ecc_scrub_seq`

## Requirements
- R1: When `fuse_ovr_dis` is 1, all six bits of `unit_en` equal `fuse_ecc_en`. The bits are ordered 0 register file, 1 L1 data, 2 L1 tag, 3 barrier/warp unit (CBU), 4 instruction cache, 5 L2. The override words are ignored in this case.
- R2: When `fuse_ovr_dis` is 0, each paired unit takes its enable from a value bit if its override bit is set, and from `fuse_ecc_en` otherwise. The (value, override) bits in `ovr_word0` are: register file (0,3), L1 data (4,7), L1 tag (8,11), L2 (12,15), CBU (20,23).
- R3: The instruction cache override in `ovr_word1` applies only when both bit 1 and bit 3 are set. In that case the cache is enabled only when both bit 0 and bit 2 are set. In every other case it follows `fuse_ecc_en`.
- R4: Units are scrubbed in the order register file, L1 data, L1 tag, CBU, instruction cache. A disabled unit causes no bus access at all.
- R5: Each enabled unit receives exactly one write, to its broadcast address. The write data is its full task mask: 0xFF for the register file, 0x3 for L1 data, 0x3 for L1 tag, 0xF for CBU and 0xF for the instruction cache.
- R6: The first status read follows the write directly. A unit completes when the read data ANDed with its mask is zero. Bits outside the mask are ignored. After each busy read the next read is issued `POLL_INTERVAL` idle cycles later.
- R7: A unit whose `POLL_BUDGET/POLL_INTERVAL`-th read is still busy has its `unit_fail` bit set, in scrub-order bit position 0..4. The sequence then continues with the next unit. A clean result on that final read counts as success.
- R8: `done` is high for exactly one cycle after the last unit has been finished or skipped.
- R9: A start pulse while a sequence is running has no effect on enables, flags or bus activity.
- R10: Reset clears `unit_en`, `unit_fail`, `done` and `reg_req`. An accepted start clears `unit_fail` and loads `unit_en`. Both then hold their values until the next accepted start.
- R11: Once `reg_req` is raised, it stays high with address, direction and write data unchanged until `reg_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request, accepted only when idle |
| fuse_ecc_en | input | 1 | Global ECC enable fuse |
| fuse_ovr_dis | input | 1 | Fuse that disables the override words |
| ovr_word0 | input | 32 | Override/value pairs for the paired units |
| ovr_word1 | input | 32 | Instruction cache override/value bits (bits 3:0) |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | ADDR_W | Register address |
| reg_wdata | output | 32 | Write data |
| reg_ack | input | 1 | Access acknowledge (read data valid) |
| reg_rdata | input | 32 | Read data |
| unit_en | output | 6 | Resolved enables captured at start |
| unit_fail | output | 5 | Per-unit timeout flags in scrub order |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
Two events can land in the same cycle: a unit's scrub completes, and that unit's poll limit is used up. This happens when the read that returns clear task bits is also the last read allowed. The bench provokes it with a responder that reports busy for exactly one read fewer than the limit. It expects success, no fail flag and exactly the limit number of reads. It then repeats the run with one more busy read and expects the fail flag set after the same number of reads.

// File: rtl/ecc_scrub_pkg.sv
package ecc_scrub_pkg;

  localparam int WORD_W     = 32;
  localparam int NUM_SCRUB  = 5;   // units visited, in scrub order
  localparam int NUM_EN     = 6;   // resolved enables (scrub units + L2)
  localparam int NUM_PAIRED = 5;   // units described by word0 pairs

  // enable vector positions; 0..4 also equal scrub order
  localparam int EN_RF     = 0;
  localparam int EN_L1D    = 1;
  localparam int EN_L1T    = 2;
  localparam int EN_CBU    = 3;
  localparam int EN_ICACHE = 4;
  localparam int EN_L2     = 5;

  // instruction cache bits inside word1
  localparam int IC_L0_VAL = 0;
  localparam int IC_L0_OVR = 1;
  localparam int IC_L1_VAL = 2;
  localparam int IC_L1_OVR = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PICK,
    ST_WRITE,
    ST_READ,
    ST_WAIT
  } seq_state_e;

  // task mask of a unit, indexed by scrub order
  function automatic logic [WORD_W-1:0] scrub_mask(input int unsigned idx);
    case (idx)
      0:       return WORD_W'(32'h0000_00FF);
      1, 2:    return WORD_W'(32'h0000_0003);
      3, 4:    return WORD_W'(32'h0000_000F);
      default: return '0;
    endcase
  endfunction

  // value bit of paired unit p in word0
  function automatic int pair_val_pos(input int p);
    case (p)
      0:       return 0;
      1:       return 4;
      2:       return 8;
      3:       return 12;
      default: return 20;
    endcase
  endfunction

  // override bit sits three places above its value bit
  function automatic int pair_ovr_pos(input int p);
    return pair_val_pos(p) + 3;
  endfunction

  // enable vector position fed by paired unit p
  function automatic int pair_dst(input int p);
    case (p)
      0:       return EN_RF;
      1:       return EN_L1D;
      2:       return EN_L1T;
      3:       return EN_L2;
      default: return EN_CBU;
    endcase
  endfunction

  function automatic logic take_enable(input logic fuse, input logic ovr,
                                       input logic val);
    return ovr ? val : fuse;
  endfunction

endpackage

// File: rtl/ecc_en_resolver.sv
module ecc_en_resolver
  import ecc_scrub_pkg::*;
(
  input  logic              fuse_ecc_en,
  input  logic              fuse_ovr_dis,
  input  logic [WORD_W-1:0] ovr_word0,
  input  logic [WORD_W-1:0] ovr_word1,
  output logic [NUM_EN-1:0] en
);

  logic [NUM_EN-1:0] per_unit;

  for (genvar p = 0; p < NUM_PAIRED; p++) begin : g_pair
    localparam int VP  = pair_val_pos(p);
    localparam int OP  = pair_ovr_pos(p);
    localparam int DST = pair_dst(p);
    assign per_unit[DST] = take_enable(fuse_ecc_en, ovr_word0[OP], ovr_word0[VP]);
  end

  logic ic_ovr;
  logic ic_val;
  assign ic_ovr = ovr_word1[IC_L0_OVR] & ovr_word1[IC_L1_OVR];
  assign ic_val = ovr_word1[IC_L0_VAL] & ovr_word1[IC_L1_VAL];
  assign per_unit[EN_ICACHE] = take_enable(fuse_ecc_en, ic_ovr, ic_val);

  assign en = fuse_ovr_dis ? {NUM_EN{fuse_ecc_en}} : per_unit;

  // reserved bits of the override words carry no meaning here
  logic unused_ovr_bits;
  assign unused_ovr_bits = ^{ovr_word0, ovr_word1};

endmodule

// File: rtl/ecc_poll_pacer.sv
module ecc_poll_pacer #(
  parameter int INTERVAL = 10,
  parameter int LIMIT    = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,      // unit launched: restart poll accounting
  input  logic retry,      // a status read came back busy
  output logic wait_done,  // spacing interval has elapsed
  output logic last_poll   // the read in flight is the final one allowed
);

  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam int TMR_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(LIMIT - 1);
  localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(INTERVAL - 1);

  logic [CNT_W-1:0] poll_cnt;
  logic [TMR_W-1:0] tmr;
  logic             waiting;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poll_cnt <= '0;
      tmr      <= '0;
      waiting  <= 1'b0;
    end else if (clear) begin
      poll_cnt <= '0;
      tmr      <= '0;
      waiting  <= 1'b0;
    end else if (retry) begin
      poll_cnt <= poll_cnt + 1'b1;
      tmr      <= TMR_LOAD;
      waiting  <= 1'b1;
    end else if (waiting) begin
      if (tmr == '0) waiting <= 1'b0;
      else           tmr <= tmr - 1'b1;
    end
  end

  assign wait_done = waiting && (tmr == '0);
  assign last_poll = (poll_cnt == LAST_CNT);

  // R6: the sequencer never reports a busy read while a spacing interval runs
  p_no_retry_while_waiting_r6: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> !retry);

endmodule

// File: rtl/ecc_scrub_seq.sv
module ecc_scrub_seq
  import ecc_scrub_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int POLL_INTERVAL = 10,
  parameter int POLL_BUDGET   = 1000,
  parameter logic [NUM_SCRUB-1:0][ADDR_W-1:0] BCAST_ADDR =
    {16'h4140, 16'h4130, 16'h4120, 16'h4110, 16'h4100},
  parameter logic [NUM_SCRUB-1:0][ADDR_W-1:0] STAT_ADDR =
    {16'h8140, 16'h8130, 16'h8120, 16'h8110, 16'h8100}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 fuse_ecc_en,
  input  logic                 fuse_ovr_dis,
  input  logic [WORD_W-1:0]    ovr_word0,
  input  logic [WORD_W-1:0]    ovr_word1,
  output logic                 reg_req,
  output logic                 reg_we,
  output logic [ADDR_W-1:0]    reg_addr,
  output logic [WORD_W-1:0]    reg_wdata,
  input  logic                 reg_ack,
  input  logic [WORD_W-1:0]    reg_rdata,
  output logic [NUM_EN-1:0]    unit_en,
  output logic [NUM_SCRUB-1:0] unit_fail,
  output logic                 done
);

  localparam int POLL_LIMIT = POLL_BUDGET / POLL_INTERVAL;
  localparam int IDX_W      = $clog2(NUM_SCRUB + 1);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(NUM_SCRUB);

  seq_state_e state, state_nx;
  logic [IDX_W-1:0]     idx;
  logic [NUM_EN-1:0]    en_q;
  logic [NUM_SCRUB-1:0] fail_q;
  logic                 done_q;
  logic [NUM_EN-1:0]    en_resolved;

  // named internal events
  logic                 start_acc;
  logic                 idx_valid;
  logic                 cur_en;
  logic [WORD_W-1:0]    cur_mask;
  logic                 write_ack;
  logic                 read_clean;
  logic                 read_busy;
  logic                 give_up;
  logic                 retry;
  logic                 skip_unit;
  logic                 advance;
  logic                 seq_end;
  logic                 wait_done;
  logic                 last_poll;

  ecc_en_resolver u_resolver (
    .fuse_ecc_en  (fuse_ecc_en),
    .fuse_ovr_dis (fuse_ovr_dis),
    .ovr_word0    (ovr_word0),
    .ovr_word1    (ovr_word1),
    .en           (en_resolved)
  );

  ecc_poll_pacer #(
    .INTERVAL (POLL_INTERVAL),
    .LIMIT    (POLL_LIMIT)
  ) u_pacer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (write_ack),
    .retry     (retry),
    .wait_done (wait_done),
    .last_poll (last_poll)
  );

  assign start_acc  = start && (state == ST_IDLE);
  assign idx_valid  = (idx < IDX_END);
  assign cur_en     = idx_valid && en_q[idx];
  assign cur_mask   = scrub_mask(32'(idx));
  assign write_ack  = (state == ST_WRITE) && reg_ack;
  assign read_clean = (state == ST_READ) && reg_ack && ((reg_rdata & cur_mask) == '0);
  assign read_busy  = (state == ST_READ) && reg_ack && !read_clean;
  assign give_up    = read_busy && last_poll;
  assign retry      = read_busy && !last_poll;
  assign skip_unit  = (state == ST_PICK) && idx_valid && !cur_en;
  assign advance    = skip_unit || read_clean || give_up;
  assign seq_end    = (state == ST_PICK) && !idx_valid;

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:  if (start)            state_nx = ST_PICK;
      ST_PICK:  if (!idx_valid)       state_nx = ST_IDLE;
                else if (cur_en)      state_nx = ST_WRITE;
      ST_WRITE: if (reg_ack)          state_nx = ST_READ;
      ST_READ:  if (read_clean || give_up) state_nx = ST_PICK;
                else if (retry)       state_nx = ST_WAIT;
      ST_WAIT:  if (wait_done)        state_nx = ST_READ;
      default:                        state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      idx    <= '0;
      en_q   <= '0;
      fail_q <= '0;
      done_q <= 1'b0;
    end else begin
      state  <= state_nx;
      done_q <= seq_end;
      if (start_acc) begin
        idx    <= '0;
        en_q   <= en_resolved;
        fail_q <= '0;
      end else begin
        if (give_up) fail_q[idx] <= 1'b1;
        if (advance) idx <= idx + 1'b1;
      end
    end
  end

  // bus master outputs follow the state directly
  always_comb begin
    reg_req   = (state == ST_WRITE) || (state == ST_READ);
    reg_we    = (state == ST_WRITE);
    reg_wdata = (state == ST_WRITE) ? cur_mask : '0;
    reg_addr  = '0;
    if (idx_valid) begin
      if (state == ST_WRITE)     reg_addr = BCAST_ADDR[idx];
      else if (state == ST_READ) reg_addr = STAT_ADDR[idx];
    end
  end

  assign unit_en   = en_q;
  assign unit_fail = fail_q;
  assign done      = done_q;

  // R11: request held steady until acknowledged
  p_bus_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_ack) |=> (reg_req && $stable(reg_addr) && $stable(reg_we)
                               && $stable(reg_wdata)));

  // R4: every access belongs to an enabled unit
  p_access_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |-> (idx_valid && unit_en[idx]));

  // R8: done is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: enables change only on an accepted start
  p_en_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !start_acc |=> $stable(unit_en));

  // R7: within a run, fail flags only ever rise
  p_fail_rise_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !start_acc |=> (($past(unit_fail) & ~unit_fail) == '0));

  // R9: a start during a run leaves the sequencer busy
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state != ST_IDLE && !seq_end) |=> (state != ST_IDLE));

endmodule

// File: tb/tb_ecc_scrub_seq.sv
`timescale 1ns/1ps
module tb_ecc_scrub_seq;

  localparam int TB_INTERVAL = 10;
  localparam int TB_BUDGET   = 1000;
  localparam int TB_LIMIT    = TB_BUDGET / TB_INTERVAL;
  localparam int LOGN        = 2048;
  localparam logic [4:0][15:0] TB_BCAST =
    {16'h0A40, 16'h0A30, 16'h0A20, 16'h0A10, 16'h0A00};
  localparam logic [4:0][15:0] TB_STAT =
    {16'h5140, 16'h5130, 16'h5120, 16'h5110, 16'h5100};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        fuse = 1'b0;
  logic        dis = 1'b0;
  logic [31:0] ow0 = '0;
  logic [31:0] ow1 = '0;
  logic        req, we;
  logic [15:0] addr;
  logic [31:0] wdata;
  logic        ack;
  logic [31:0] rdata;
  logic [5:0]  en;
  logic [4:0]  fail;
  logic        done;

  always #2.5 clk = ~clk;

  ecc_scrub_seq #(
    .ADDR_W(16), .POLL_INTERVAL(TB_INTERVAL), .POLL_BUDGET(TB_BUDGET),
    .BCAST_ADDR(TB_BCAST), .STAT_ADDR(TB_STAT)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .fuse_ecc_en(fuse),
    .fuse_ovr_dis(dis), .ovr_word0(ow0), .ovr_word1(ow1),
    .reg_req(req), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_ack(ack), .reg_rdata(rdata), .unit_en(en), .unit_fail(fail),
    .done(done)
  );

  int n_checks = 0;
  int n_fail   = 0;

  function automatic logic [31:0] tb_mask(input int k);
    case (k)
      0: return 32'hFF;
      1: return 32'h3;
      2: return 32'h3;
      default: return 32'hF;
    endcase
  endfunction

  // independent enable model: bits 0 RF,1 L1D,2 L1T,3 CBU,4 IC,5 L2
  function automatic logic [5:0] model_en(input logic f, input logic d,
                                          input logic [31:0] w0, input logic [31:0] w1);
    int vpos [5] = '{0, 4, 8, 12, 20};
    int dst  [5] = '{0, 1, 2, 5, 3};
    logic [5:0] r;
    if (d) return {6{f}};
    r = '0;
    for (int p = 0; p < 5; p++)
      r[dst[p]] = w0[vpos[p] + 3] ? w0[vpos[p]] : f;
    r[4] = (w1[1] && w1[3]) ? (w1[0] && w1[2]) : f;
    return r;
  endfunction

  // responder model
  int          busy_cfg [5] = '{0, 0, 0, 0, 0};
  int          rd_cnt   [5] = '{0, 0, 0, 0, 0};
  logic        log_we   [LOGN];
  logic [15:0] log_addr [LOGN];
  logic [31:0] log_wd   [LOGN];
  int          log_cyc  [LOGN];
  int          log_n = 0;
  int          cyc = 0;
  int          done_cnt = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      ack   <= 1'b0;
      rdata <= '0;
    end else begin
      ack <= 1'b0;
      if (req && !ack) begin
        ack <= 1'b1;
        if (log_n < LOGN) begin
          log_we[log_n]   <= we;
          log_addr[log_n] <= addr;
          log_wd[log_n]   <= wdata;
          log_cyc[log_n]  <= cyc;
          log_n <= log_n + 1;
        end
        for (int k = 0; k < 5; k++) begin
          if (we && addr == TB_BCAST[k]) rd_cnt[k] <= 0;
          if (!we && addr == TB_STAT[k]) begin
            // unrelated high bits always set; busy shows one task bit
            rdata <= (rd_cnt[k] < busy_cfg[k])
                     ? (32'hFFFF_0000 | (tb_mask(k) & ~(tb_mask(k) >> 1)))
                     : 32'hFFFF_0000;
            rd_cnt[k] <= rd_cnt[k] + 1;
          end
        end
      end
    end
  end

  always @(posedge clk) if (rst_n && done) done_cnt <= done_cnt + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic run_seq(input logic f, input logic d, input logic [31:0] w0,
                         input logic [31:0] w1, output int base);
    int d0;
    @(negedge clk);
    fuse = f; dis = d; ow0 = w0; ow1 = w1;
    base = log_n;
    d0 = done_cnt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < 20000 && done_cnt == d0; n++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(done_cnt == d0 + 1, "R8", "done pulses per run", done_cnt - d0, 1);
  endtask

  task automatic expect_access(input int pos, input logic w, input logic [15:0] a,
                               input logic [31:0] wd, input string tag);
    chk(log_we[pos] == w, tag, "access direction", log_we[pos], w);
    chk(log_addr[pos] == a, tag, "access address", log_addr[pos], a);
    if (w) chk(log_wd[pos] == wd, tag, "write mask", log_wd[pos], wd);
  endtask

  function automatic int reads_of(input int k, input int from, input int to);
    int c = 0;
    for (int i = from; i < to; i++)
      if (!log_we[i] && log_addr[i] == TB_STAT[k]) c++;
    return c;
  endfunction

  // scenario: all units via locked fuse
  task automatic t_all_enabled();
    int b;
    run_seq(1'b1, 1'b1, 32'h0, 32'h0, b);
    chk(en == 6'h3F, "R1", "enables with overrides locked", en, 6'h3F);
    chk(log_n - b == 10, "R4", "access count", log_n - b, 10);
    for (int k = 0; k < 5; k++) begin
      expect_access(b + 2*k, 1'b1, TB_BCAST[k], tb_mask(k), "R5");
      expect_access(b + 2*k + 1, 1'b0, TB_STAT[k], 32'h0, "R4");
    end
    chk(fail == 5'h0, "R6", "no fail on clean scrub", fail, 0);
  endtask

  task automatic t_fuse_off_locked();
    int b;
    run_seq(1'b0, 1'b1, 32'hFFFF_FFFF, 32'hF, b);
    chk(en == 6'h00, "R1", "override words ignored", en, 0);
    chk(log_n == b, "R4", "no access when all disabled", log_n - b, 0);
  endtask

  task automatic t_overrides();
    int b;
    logic [31:0] w0;
    logic [5:0]  exp;
    // RF ovr=1 val=1; L1D ovr=1 val=0; L1T no ovr; L2 ovr val 1; CBU ovr val 1
    w0 = 32'h0000_0000 | (32'h9) | (32'h1 << 7) | (32'h9 << 12) | (32'h9 << 20);
    exp = model_en(1'b0, 1'b0, w0, 32'hF);
    run_seq(1'b0, 1'b0, w0, 32'hF, b);
    chk(en == exp, "R2", "per-unit override resolution", en, exp);
    chk(en == 6'b111001, "R3", "cache enabled by both values", en, 6'b111001);
    chk(log_n - b == 6, "R4", "skipped units cause no access", log_n - b, 6);
    expect_access(b,     1'b1, TB_BCAST[0], 32'hFF, "R4");
    expect_access(b + 2, 1'b1, TB_BCAST[3], 32'hF,  "R4");
    expect_access(b + 4, 1'b1, TB_BCAST[4], 32'hF,  "R4");
  endtask

  task automatic t_icache_rules();
    int b;
    logic [5:0] exp;
    exp = model_en(1'b1, 1'b0, 32'h0, 32'hA);
    run_seq(1'b1, 1'b0, 32'h0, 32'hA, b);
    chk(en == exp && en[4] == 1'b0, "R3", "both overrides, values clear", en, exp);
    chk(reads_of(4, b, log_n) == 0, "R3", "disabled cache not polled",
        reads_of(4, b, log_n), 0);
    exp = model_en(1'b1, 1'b0, 32'h0, 32'h2);
    run_seq(1'b1, 1'b0, 32'h0, 32'h2, b);
    chk(en == exp && en[4] == 1'b1, "R3", "single override falls back to fuse", en, exp);
  endtask

  task automatic t_spacing();
    int b;
    int p [4];
    int np = 0;
    busy_cfg[0] = 3;
    run_seq(1'b1, 1'b1, 32'h0, 32'h0, b);
    busy_cfg[0] = 0;
    for (int i = b; i < log_n; i++)
      if (!log_we[i] && log_addr[i] == TB_STAT[0] && np < 4) begin
        p[np] = i; np++;
      end
    chk(np == 4, "R6", "reads until clear", np, 4);
    chk(p[0] == b + 1, "R6", "first read right after write", p[0] - b, 1);
    for (int j = 1; j < 4; j++)
      chk(log_cyc[p[j]] - log_cyc[p[j-1]] == TB_INTERVAL + 2, "R6", "poll spacing",
          log_cyc[p[j]] - log_cyc[p[j-1]], TB_INTERVAL + 2);
    chk(fail == 5'h0, "R6", "busy then clean is success", fail, 0);
  endtask

  task automatic t_timeout();
    int b;
    busy_cfg[1] = 5000;
    run_seq(1'b1, 1'b1, 32'h0, 32'h0, b);
    busy_cfg[1] = 0;
    chk(fail == 5'b00010, "R7", "fail flag of stuck unit", fail, 5'b00010);
    chk(reads_of(1, b, log_n) == TB_LIMIT, "R7", "reads before giving up",
        reads_of(1, b, log_n), TB_LIMIT);
    expect_access(log_n - 4, 1'b1, TB_BCAST[3], 32'hF, "R7");
    expect_access(log_n - 2, 1'b1, TB_BCAST[4], 32'hF, "R7");
    // fail cleared by the next accepted start
    @(negedge clk);
    fuse = 1'b1; dis = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(fail == 5'h0, "R10", "fail cleared at start", fail, 0);
    for (int n = 0; n < 2000 && dut.done == 1'b0; n++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_last_poll();
    int b;
    busy_cfg[2] = TB_LIMIT - 1;
    run_seq(1'b1, 1'b1, 32'h0, 32'h0, b);
    chk(fail == 5'h0, "R7", "clean on final poll is success", fail, 0);
    chk(reads_of(2, b, log_n) == TB_LIMIT, "R7", "reads on final-poll success",
        reads_of(2, b, log_n), TB_LIMIT);
    busy_cfg[2] = TB_LIMIT;
    run_seq(1'b1, 1'b1, 32'h0, 32'h0, b);
    busy_cfg[2] = 0;
    chk(fail == 5'b00100, "R7", "busy on final poll fails", fail, 5'b00100);
    chk(reads_of(2, b, log_n) == TB_LIMIT, "R7", "reads on final-poll failure",
        reads_of(2, b, log_n), TB_LIMIT);
  endtask

  task automatic t_start_ignored();
    int b, d0, wr;
    busy_cfg[0] = 5;
    @(negedge clk);
    fuse = 1'b1; dis = 1'b1; ow0 = '0; ow1 = '0;
    b = log_n; d0 = done_cnt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (12) @(negedge clk);
    fuse = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < 5000 && done_cnt == d0; n++) @(negedge clk);
    repeat (3) @(negedge clk);
    busy_cfg[0] = 0;
    wr = 0;
    for (int i = b; i < log_n; i++) if (log_we[i]) wr++;
    chk(en == 6'h3F, "R9", "enables kept through ignored start", en, 6'h3F);
    chk(wr == 5, "R9", "one write per unit, no restart", wr, 5);
    chk(done_cnt == d0 + 1, "R9", "single done", done_cnt - d0, 1);
    repeat (5) @(negedge clk);
    chk(en == 6'h3F && fail == 5'h0, "R10", "outputs hold after done", en, 6'h3F);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(en == 6'h0 && fail == 5'h0, "R10", "reset enables/flags", {en, fail}, 0);
    chk(done == 1'b0 && req == 1'b0, "R10", "reset done/req", {done, req}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_all_enabled();
    t_fuse_off_locked();
    t_overrides();
    t_icache_rules();
    t_spacing();
    t_timeout();
    t_last_poll();
    t_start_ignored();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule